// File: doc/BRIEF.md
# SDRAM Open-Page Tracker

This block keeps a small table of the SDRAM rows that are currently open across all chip-enable regions of a memory controller. Each access arrives as a 32-bit logical address. The block splits the address into region, bank, row and column fields and compares them against the table. It then tells the command sequencer which of three paths to take. On a page hit it reads or writes at once. On an idle bank it activates first. On a page miss it precharges a named row and then activates. It also updates the table for the row the access will leave open.

Rows are never closed just because an access finished. An entry leaves the table only in three cases: a later access to the same bank of the same region needs a different row, the table is full and its least recently used entry must make room, or the refresh logic pulses the close-all input. Up to four entries are shared freely among the regions.

Both the address input and the decision output use valid/ready. An address is taken on a clock edge where `in_valid` and `in_ready` are both high. The decision appears one cycle later on the output and stays there, unchanged, until `out_ready` is seen high. While a decision is waiting, `in_ready` is low. It is also low during a close-all pulse, so an access and a clear never happen in the same cycle.

Top module: `sdram_page_tracker`

## Requirements
- R1: Address fields are decoded as region = bits [31:28], bank = bit [21], row = bits [20:10] and column = bits [9:2]. Bits [1:0] are the byte offset and are ignored.
- R2: An access whose region, bank and row all match a valid entry yields command code 2'b00 (direct read/write). The table contents are left unchanged.
- R3: An access to a region/bank pair that has no entry, while a free entry exists, yields code 2'b01 (activate first). The new row is stored in the lowest-numbered free entry.
- R4: An access to a region/bank pair that holds a different open row yields code 2'b10 (precharge then activate). The victim outputs carry the old row of that same region and bank, and the new row replaces it in that entry.
- R5: A row stays open after its access completes, so repeating the access yields 2'b00. Four rows may be open together, in any mix of regions.
- R6: When all four entries are valid and the access maps to a region/bank pair with no entry, the result is 2'b10. The victim outputs carry the least recently used entry, and that entry is overwritten. Any lookup, whether hit, replacement or allocation, makes its entry the most recently used.
- R7: A one-cycle `close_all` pulse invalidates every entry in one cycle, so the next access to any row yields 2'b01. `in_ready` is low while `close_all` is high.
- R8: While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_ready` stays low.
- R9: After reset no entry is valid, `out_valid` is low and `in_ready` is high.
- R10: The table never holds two valid entries for the same region and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| close_all | input | 1 | One-cycle pulse that invalidates every open-row entry |
| in_valid | input | 1 | Access address is valid |
| in_ready | output | 1 | Block can take an address this cycle |
| in_addr | input | 32 | Logical byte address of the access |
| out_valid | output | 1 | Decision is valid |
| out_ready | input | 1 | Sequencer takes the decision |
| out_cmd | output | 2 | 00 read/write, 01 activate first, 10 precharge then activate |
| out_region | output | 4 | Region of the access |
| out_bank | output | 1 | Bank of the access |
| out_row | output | 11 | Row of the access |
| out_col | output | 8 | Column of the access |
| out_victim_region | output | 4 | Region of the row to precharge (valid for code 10) |
| out_victim_bank | output | 1 | Bank of the row to precharge (valid for code 10) |
| out_victim_row | output | 11 | Row to precharge (valid for code 10) |

## Verification
The hardest case to reach is least-recently-used eviction while the table is full. It needs four distinct region/bank pairs open, a known recency order among them, and then an access to a fifth pair. A directed sequence opens four pages across two regions and touches them in a chosen order before the fifth access. Random traffic is drawn from six region/bank pairs with only three rows each. This mix produces frequent hits, bank conflicts and full-table evictions, and a bench model of the table predicts every victim. Close-all pulses and output stalls are placed between accesses.

// File: rtl/sdram_opt_pkg.sv
package sdram_opt_pkg;
  typedef enum logic [1:0] {
    CMD_RW      = 2'b00,
    CMD_ACT     = 2'b01,
    CMD_PRE_ACT = 2'b10
  } page_cmd_e;
endpackage

// File: rtl/opt_addr_split.sv
module opt_addr_split #(
  parameter int ADDR_W   = 32,
  parameter int COL_LSB  = 2,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 11,
  parameter int BANK_W   = 1,
  parameter int REGION_W = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [REGION_W-1:0] region,
  output logic [BANK_W-1:0]   bank,
  output logic [ROW_W-1:0]    row,
  output logic [COL_W-1:0]    col
);
  localparam int ROW_LSB    = COL_LSB + COL_W;
  localparam int BANK_LSB   = ROW_LSB + ROW_W;
  localparam int REGION_LSB = ADDR_W - REGION_W;

  assign col    = addr[ROW_LSB-1:COL_LSB];
  assign row    = addr[BANK_LSB-1:ROW_LSB];
  assign bank   = addr[BANK_LSB+BANK_W-1:BANK_LSB];
  assign region = addr[ADDR_W-1:REGION_LSB];
endmodule

// File: rtl/opt_page_table.sv
module opt_page_table #(
  parameter int N_ENT    = 4,
  parameter int REGION_W = 4,
  parameter int BANK_W   = 1,
  parameter int ROW_W    = 11,
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                lk_en,
  input  logic [REGION_W-1:0] lk_region,
  input  logic [BANK_W-1:0]   lk_bank,
  input  logic [ROW_W-1:0]    lk_row,
  output logic [N_ENT-1:0]    hit_vec,
  output logic [N_ENT-1:0]    bank_vec,
  output logic [N_ENT-1:0]    valid_vec,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [REGION_W-1:0] rd_region,
  output logic [BANK_W-1:0]   rd_bank,
  output logic [ROW_W-1:0]    rd_row,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic [ROW_W-1:0]    wr_row
);
  logic [N_ENT-1:0]               vld_q;
  logic [N_ENT-1:0][REGION_W-1:0] reg_q;
  logic [N_ENT-1:0][BANK_W-1:0]   bank_q;
  logic [N_ENT-1:0][ROW_W-1:0]    row_q;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        reg_q[e]  <= '0;
        bank_q[e] <= '0;
        row_q[e]  <= '0;
      end else if (clear) begin
        vld_q[e]  <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        vld_q[e]  <= 1'b1;
        reg_q[e]  <= wr_region;
        bank_q[e] <= wr_bank;
        row_q[e]  <= wr_row;
      end
    end

    assign bank_vec[e] = vld_q[e] && (reg_q[e] == lk_region) && (bank_q[e] == lk_bank);
    assign hit_vec[e]  = bank_vec[e] && (row_q[e] == lk_row);
  end

  assign valid_vec = vld_q;
  assign rd_region = reg_q[rd_idx];
  assign rd_bank   = bank_q[rd_idx];
  assign rd_row    = row_q[rd_idx];

  a_r10_one_row_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |-> $onehot0(bank_vec));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_vec == '0));
endmodule

// File: rtl/opt_lru.sv
module opt_lru #(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N_ENT-1:0] valid_vec,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_ENT - 1);

  logic [N_ENT-1:0][IDX_W-1:0] age_q;
  logic [IDX_W-1:0]            touched_age;
  logic [N_ENT-1:0]            oldest_vec;

  assign touched_age = age_q[touch_idx];

  for (genvar e = 0; e < N_ENT; e++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[e] <= OLDEST;
      end else if (clear) begin
        age_q[e] <= OLDEST;
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(e))
          age_q[e] <= '0;
        else if (age_q[e] < touched_age)
          age_q[e] <= age_q[e] + 1'b1;
      end
    end
    assign oldest_vec[e] = (age_q[e] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--)
      if (oldest_vec[e]) victim_idx = IDX_W'(e);
  end

  a_r6_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> ($countones(oldest_vec) == 1));
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
  import sdram_opt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_ENT    = 4,
  parameter int COL_LSB  = 2,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 11,
  parameter int BANK_W   = 1,
  parameter int REGION_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                close_all,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_cmd,
  output logic [REGION_W-1:0] out_region,
  output logic [BANK_W-1:0]   out_bank,
  output logic [ROW_W-1:0]    out_row,
  output logic [COL_W-1:0]    out_col,
  output logic [REGION_W-1:0] out_victim_region,
  output logic [BANK_W-1:0]   out_victim_bank,
  output logic [ROW_W-1:0]    out_victim_row
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [REGION_W-1:0] a_region;
  logic [BANK_W-1:0]   a_bank;
  logic [ROW_W-1:0]    a_row;
  logic [COL_W-1:0]    a_col;
  logic [N_ENT-1:0]    hit_vec, bank_vec, valid_vec;
  logic [IDX_W-1:0]    hit_idx, bank_idx, free_idx, lru_idx, tgt_idx;
  logic [REGION_W-1:0] v_region;
  logic [BANK_W-1:0]   v_bank;
  logic [ROW_W-1:0]    v_row;
  page_cmd_e           cmd;
  logic                accept;

  opt_addr_split #(
    .ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W),
    .ROW_W(ROW_W), .BANK_W(BANK_W), .REGION_W(REGION_W)
  ) u_split (
    .addr(in_addr), .region(a_region), .bank(a_bank), .row(a_row), .col(a_col)
  );

  opt_page_table #(
    .N_ENT(N_ENT), .REGION_W(REGION_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .clear(close_all), .lk_en(in_valid),
    .lk_region(a_region), .lk_bank(a_bank), .lk_row(a_row),
    .hit_vec(hit_vec), .bank_vec(bank_vec), .valid_vec(valid_vec),
    .rd_idx(tgt_idx), .rd_region(v_region), .rd_bank(v_bank), .rd_row(v_row),
    .wr_en(accept && (cmd != CMD_RW)), .wr_idx(tgt_idx),
    .wr_region(a_region), .wr_bank(a_bank), .wr_row(a_row)
  );

  opt_lru #(.N_ENT(N_ENT)) u_lru (
    .clk(clk), .rst_n(rst_n), .clear(close_all),
    .touch_en(accept), .touch_idx(tgt_idx),
    .valid_vec(valid_vec), .victim_idx(lru_idx)
  );

  // Index encoders: lowest set bit for hit/bank match, lowest clear bit for free.
  always_comb begin
    hit_idx  = '0;
    bank_idx = '0;
    free_idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hit_vec[e])    hit_idx  = IDX_W'(e);
      if (bank_vec[e])   bank_idx = IDX_W'(e);
      if (!valid_vec[e]) free_idx = IDX_W'(e);
    end
  end

  // Decision priority: hit, same-bank conflict, free entry, LRU eviction.
  always_comb begin
    if (|hit_vec) begin
      cmd     = CMD_RW;
      tgt_idx = hit_idx;
    end else if (|bank_vec) begin
      cmd     = CMD_PRE_ACT;
      tgt_idx = bank_idx;
    end else if (!(&valid_vec)) begin
      cmd     = CMD_ACT;
      tgt_idx = free_idx;
    end else begin
      cmd     = CMD_PRE_ACT;
      tgt_idx = lru_idx;
    end
  end

  assign in_ready = (!out_valid || out_ready) && !close_all;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_cmd           <= CMD_RW;
      out_region        <= '0;
      out_bank          <= '0;
      out_row           <= '0;
      out_col           <= '0;
      out_victim_region <= '0;
      out_victim_bank   <= '0;
      out_victim_row    <= '0;
    end else if (accept) begin
      out_valid         <= 1'b1;
      out_cmd           <= cmd;
      out_region        <= a_region;
      out_bank          <= a_bank;
      out_row           <= a_row;
      out_col           <= a_col;
      out_victim_region <= v_region;
      out_victim_bank   <= v_bank;
      out_victim_row    <= v_row;
    end else if (out_ready) begin
      out_valid         <= 1'b0;
    end
  end

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cmd) && $stable(out_row)
      && $stable(out_col) && $stable(out_victim_row) && $stable(out_region)));

  a_r8_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_victim_row_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == 2'b10 && out_victim_region == out_region
      && out_victim_bank == out_bank) |-> (out_victim_row != out_row));

  a_r7_no_take_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |-> !in_ready);
endmodule

// File: tb/sdram_page_tracker_bench.sv
module sdram_page_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        close_all = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_cmd;
  logic [3:0]  out_region, out_victim_region;
  logic [0:0]  out_bank, out_victim_bank;
  logic [10:0] out_row, out_victim_row;
  logic [7:0]  out_col;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_page_tracker u_sdram_page_tracker (
    .clk(clk), .rst_n(rst_n), .close_all(close_all),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
    .out_region(out_region), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_victim_region(out_victim_region), .out_victim_bank(out_victim_bank),
    .out_victim_row(out_victim_row)
  );

  // Reference table
  bit          m_vld[4];
  logic [3:0]  m_reg[4];
  logic        m_bank[4];
  logic [10:0] m_row[4];
  int          m_age[4];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int reg_, input int bank, input int row, input int col);
    return {4'(reg_), 6'd0, 1'(bank), 11'(row), 8'(col), 2'(col >> 8)};
  endfunction

  task automatic model_clear();
    for (int e = 0; e < 4; e++) begin m_vld[e] = 0; m_age[e] = 3; end
  endtask

  task automatic model_access(input logic [31:0] a, output logic [1:0] ecmd,
                              output logic [3:0] vreg, output logic vbank, output logic [10:0] vrow);
    logic [3:0] r; logic b; logic [10:0] w;
    int t; int hit; int cnf; int fre; int old; int ta;
    r = a[31:28]; b = a[21]; w = a[20:10];
    hit = -1; cnf = -1; fre = -1; old = 0;
    for (int e = 3; e >= 0; e--) begin
      if (m_vld[e] && m_reg[e] == r && m_bank[e] == b) begin
        cnf = e;
        if (m_row[e] == w) hit = e;
      end
      if (!m_vld[e]) fre = e;
      if (m_age[e] == 3) old = e;
    end
    if (hit >= 0)      begin ecmd = 2'b00; t = hit; end
    else if (cnf >= 0) begin ecmd = 2'b10; t = cnf; end
    else if (fre >= 0) begin ecmd = 2'b01; t = fre; end
    else               begin ecmd = 2'b10; t = old; end
    vreg = m_reg[t]; vbank = m_bank[t]; vrow = m_row[t];
    ta = m_age[t];
    for (int e = 0; e < 4; e++)
      if (e == t) m_age[e] = 0;
      else if (m_age[e] < ta) m_age[e]++;
    m_vld[t] = 1; m_reg[t] = r; m_bank[t] = b; m_row[t] = w;
  endtask

  task automatic send(input logic [31:0] a, input int stall, input string req);
    logic [1:0] ecmd; logic [3:0] vreg; logic vbank; logic [10:0] vrow;
    model_access(a, ecmd, vreg, vbank, vrow);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; out_ready = (stall == 0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, req, out_valid, 1);
    check(out_cmd == ecmd, req, out_cmd, ecmd);
    check(out_region == a[31:28] && out_bank == a[21] && out_row == a[20:10] && out_col == a[9:2],
          "R1", {out_region, 6'd0, out_bank, out_row, out_col, 2'b00}, {a[31:2], 2'b00});
    if (ecmd == 2'b10)
      check(out_victim_region == vreg && out_victim_bank == vbank && out_victim_row == vrow,
            req, {out_victim_region, out_victim_bank, out_victim_row}, {vreg, vbank, vrow});
    if (stall > 0) begin
      logic [1:0] c0; logic [10:0] r0;
      c0 = out_cmd; r0 = out_row;
      repeat (stall) begin
        @(negedge clk);
        check(out_valid && out_cmd == c0 && out_row == r0, "R8", {out_cmd, out_row}, {c0, r0});
        check(in_ready == 1'b0, "R8", in_ready, 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R8", out_valid, 0);
    end
  endtask

  task automatic do_close_all();
    @(negedge clk);
    close_all = 1'b1;
    #0;
    check(in_ready == 1'b0, "R7", in_ready, 0);
    @(negedge clk);
    close_all = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_clear();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9", {in_ready, out_valid}, 2'b10);

    // R3 / R2 / R5: open, reuse, byte offset ignored
    send(mk(1, 0, 5, 10), 0, "R3");
    send(mk(1, 0, 5, 11) | 32'h3, 0, "R2");
    // R4: conflict in same bank
    send(mk(1, 0, 9, 0), 0, "R4");
    send(mk(1, 0, 9, 1), 0, "R5");
    // Fill four pages across two regions
    send(mk(1, 1, 2, 0), 0, "R3");
    send(mk(2, 0, 7, 0), 0, "R3");
    send(mk(2, 1, 3, 0), 0, "R5");
    // Touch order: make region1 bank1 the oldest
    send(mk(1, 0, 9, 4), 0, "R5");
    send(mk(2, 0, 7, 4), 0, "R5");
    send(mk(2, 1, 3, 4), 0, "R5");
    // R6: fifth pair evicts LRU (region 1 bank 1 row 2)
    send(mk(3, 0, 1, 0), 0, "R6");
    check(out_victim_region == 4'd1 && out_victim_bank == 1'b1 && out_victim_row == 11'd2,
          "R6", {out_victim_region, out_victim_bank, out_victim_row}, {4'd1, 1'b1, 11'd2});
    send(mk(1, 1, 2, 0), 0, "R6");
    // R8: stalls
    send(mk(2, 1, 3, 8), 3, "R8");
    send(mk(3, 1, 6, 8), 2, "R8");
    // R7: close all, then previous hits become activates
    do_close_all();
    send(mk(2, 1, 3, 8), 0, "R7");
    send(mk(1, 0, 9, 0), 0, "R7");

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      int rr; int rb; int rw; int rc; int st; logic [31:0] a;
      rr = $urandom % 3; rb = $urandom % 2; rw = $urandom % 3; rc = $urandom % 1024;
      st = (($urandom % 8) == 0) ? 1 + ($urandom % 3) : 0;
      a = mk(rr, rb, rw, rc);
      send(a, st, "R10");
      if (($urandom % 50) == 0) do_close_all();
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule